// File: doc/BRIEF.md
# Compare-Clear Timer Counter Core

This block is an up-counting timer whose width is set by a parameter (16 bits by default). A 3-bit source code picks which enable advances the counter. Code 0 counts on every CPU clock. Codes 1 to 6 take enables that are already synchronous to the CPU clock. Code 7 takes a toggling signal from a fast oscillator domain. That signal is resynchronized, and each of its rising edges produces one count. A start bit gates counting. A clear mode makes a compare hit against register A, or a capture-A event, return the counter to zero instead of advancing it.

Software reaches four word registers over a simple synchronous bus: control, counter, compare A and status. A write is first held in a one-entry staging register and takes effect one cycle later. Because of this, a read issued straight after a write still returns the old value. The source code can only be changed while the counter is stopped. After a change, bus writes are refused for a short settling window. The block drives a sticky compare-A flag and a one-cycle pulse that marks each hardware clear.

Top module: `cc_timer_core`

## Requirements
- R1: After reset, reads return 0 from control, counter, compare A and status, and both cmp_a_match_o and cleared_o are low.
- R2: The counter advances by one per enabled source cycle only while start (control bit 0) is 1. With start at 0 the counter holds its value.
- R3: The source code sits in control bits 4:2. Code 0 counts every clock. Codes 1 to 6 count when src_en_i[code-1] is high. Code 7 counts once per rising edge of fast_src_i, after a two-flop synchronizer.
- R4: With clear mode on (control bit 1) and counting started, a compare-A hit or a cap_a_i pulse loads 0 into the counter. cleared_o is high for exactly the following cycle, and in that cycle the counter reads 0.
- R5: A hardware clear overrides a counter write that takes effect in the same cycle, and the written value is lost.
- R6: Writes take effect one cycle after the bus cycle that carries them. Read data appears on rdata_o one cycle after the read request. A read on the bus cycle directly after a write returns the old value, and the read after that returns the new value.
- R7: A change of the source code is taken only while start is 0. A write with a different code while running leaves the code unchanged. Once a change is taken, bus writes in the next two cycles are dropped.
- R8: With clear mode off, the counter wraps from all ones to 0 and sets the overflow flag (status bit 1). Writing 0 to that bit clears it. Writing 1 leaves it unchanged.
- R9: The compare-A flag (status bit 0, also driven on cmp_a_match_o) sets on a counting cycle in which the counter equals compare A. It stays set until software writes 0 to bit 0.
- R10: A counter write replaces the increment of the cycle in which it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_en_i | input | 6 | Synchronous count enables for source codes 1 to 6 |
| fast_src_i | input | 1 | Toggling count source from the fast oscillator domain |
| cap_a_i | input | 1 | Capture-A event pulse |
| req_i | input | 1 | Bus cycle request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Register select: 0 control, 1 counter, 2 compare A, 3 status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read request |
| cmp_a_match_o | output | 1 | Sticky compare-A match flag |
| cleared_o | output | 1 | One-cycle pulse following a hardware clear |

## Verification
The hardest case to reach is a hardware clear and a counter write taking effect on the same edge. The write is staged for one cycle before it applies, so the stimulus places a cap_a_i pulse in the cycle right after the write's bus cycle. The lockout window is reached by issuing back-to-back writes straight after a source change. A behavioural reference model then tracks staging, lockout and clear priority, and its predictions are compared with every output on every cycle, through directed phases and a long random phase.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CMPA  = 2'd2,
    A_STAT  = 2'd3
  } cc_addr_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_CLRM_BIT  = 1;
  localparam int CTRL_SEL_LSB   = 2;
  localparam int STAT_MATCH_BIT = 0;
  localparam int STAT_OVF_BIT   = 1;
endpackage

// File: rtl/cc_fast_sync.sv
module cc_fast_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // top stage is history only, used for edge detect
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/cc_src_select.sv
module cc_src_select #(
  parameter int SEL_W = 3,
  localparam int NUM_SRC = 1 << SEL_W,
  localparam int NUM_EXT = NUM_SRC - 2
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EXT-1:0] ext_en_i,
  input  logic               fast_tick_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] src_vec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g == 0) begin : g_cpu
      assign src_vec[g] = 1'b1;
    end else if (g == NUM_SRC - 1) begin : g_fast
      assign src_vec[g] = fast_tick_i;
    end else begin : g_ext
      assign src_vec[g] = ext_en_i[g-1];
    end
  end

  assign tick_o = src_vec[sel_i];
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_mode_i,
  input  logic             tick_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             ovf_o,
  output logic             hw_clr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             count_en;

  assign count_en = start_i & tick_i;
  assign match_o  = count_en & (cnt_q == cmp_i);
  assign hw_clr_o = start_i & clr_mode_i & (match_o | cap_i);
  assign ovf_o    = count_en & ~clr_mode_i & (&cnt_q);

  // priority: hardware clear, software write, increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (hw_clr_o) cnt_q <= '0;
    else if (wr_i)     cnt_q <= wr_data_i;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cc_timer_core.sv
module cc_timer_core
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYC    = 2,
  localparam int NUM_EXT    = (1 << SEL_W) - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] src_en_i,
  input  logic               fast_src_i,
  input  logic               cap_a_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic               cmp_a_match_o,
  output logic               cleared_o
);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  logic             pend_v_q;
  cc_addr_e         pend_a_q;
  logic [CNT_W-1:0] pend_d_q;
  logic             start_q, clrm_q;
  logic [SEL_W-1:0] sel_q, sel_new;
  logic [LOCK_W-1:0] lock_q;
  logic [CNT_W-1:0] cmpa_q, cnt_q, rdata_q, ctrl_rd, stat_rd;
  logic             match_flag_q, ovf_flag_q, cleared_q;
  logic             accept, wr_ctrl, wr_cnt, wr_cmpa, wr_stat, sel_chg;
  logic             fast_rise, src_tick, match_evt, ovf_evt, hw_clr;

  cc_fast_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (fast_src_i),
    .rise_o  (fast_rise)
  );

  cc_src_select #(.SEL_W(SEL_W)) u_sel (
    .sel_i       (sel_q),
    .ext_en_i    (src_en_i),
    .fast_tick_i (fast_rise),
    .tick_o      (src_tick)
  );

  cc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_q),
    .clr_mode_i (clrm_q),
    .tick_i     (src_tick),
    .cap_i      (cap_a_i),
    .cmp_i      (cmpa_q),
    .wr_i       (wr_cnt),
    .wr_data_i  (pend_d_q),
    .cnt_o      (cnt_q),
    .match_o    (match_evt),
    .ovf_o      (ovf_evt),
    .hw_clr_o   (hw_clr)
  );

  // posted write stage; writes in the settling window are dropped
  assign accept = req_i & we_i & (lock_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_a_q <= A_CTRL;
      pend_d_q <= '0;
    end else begin
      pend_v_q <= accept;
      if (accept) begin
        pend_a_q <= cc_addr_e'(addr_i);
        pend_d_q <= wdata_i;
      end
    end
  end

  assign wr_ctrl = pend_v_q & (pend_a_q == A_CTRL);
  assign wr_cnt  = pend_v_q & (pend_a_q == A_COUNT);
  assign wr_cmpa = pend_v_q & (pend_a_q == A_CMPA);
  assign wr_stat = pend_v_q & (pend_a_q == A_STAT);
  assign sel_new = pend_d_q[CTRL_SEL_LSB +: SEL_W];
  assign sel_chg = wr_ctrl & ~start_q & (sel_new != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      clrm_q  <= 1'b0;
      sel_q   <= '0;
      lock_q  <= '0;
      cmpa_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        start_q <= pend_d_q[CTRL_START_BIT];
        clrm_q  <= pend_d_q[CTRL_CLRM_BIT];
      end
      if (sel_chg) sel_q <= sel_new;
      if (sel_chg)             lock_q <= LOCK_W'(LOCK_CYC);
      else if (lock_q != '0)   lock_q <= lock_q - 1'b1;
      if (wr_cmpa) cmpa_q <= pend_d_q;
    end
  end

  // status: set event wins over a same-cycle write of 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_flag_q <= 1'b0;
      ovf_flag_q   <= 1'b0;
      cleared_q    <= 1'b0;
    end else begin
      match_flag_q <= match_evt | (match_flag_q & ~(wr_stat & ~pend_d_q[STAT_MATCH_BIT]));
      ovf_flag_q   <= ovf_evt   | (ovf_flag_q   & ~(wr_stat & ~pend_d_q[STAT_OVF_BIT]));
      cleared_q    <= hw_clr;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_START_BIT] = start_q;
    ctrl_rd[CTRL_CLRM_BIT]  = clrm_q;
    ctrl_rd[CTRL_SEL_LSB +: SEL_W] = sel_q;
    stat_rd = '0;
    stat_rd[STAT_MATCH_BIT] = match_flag_q;
    stat_rd[STAT_OVF_BIT]   = ovf_flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i & ~we_i) begin
      unique case (cc_addr_e'(addr_i))
        A_CTRL:  rdata_q <= ctrl_rd;
        A_COUNT: rdata_q <= cnt_q;
        A_CMPA:  rdata_q <= cmpa_q;
        default: rdata_q <= stat_rd;
      endcase
    end
  end

  assign rdata_o       = rdata_q;
  assign cmp_a_match_o = match_flag_q;
  assign cleared_o     = cleared_q;
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3,
  parameter int LOCK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              cmp_a_match_o,
  input logic              cleared_o,
  input logic              start_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [LOCK_W-1:0] lock_q,
  input logic              pend_v_q,
  input cc_addr_e          pend_a_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R2
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && !(pend_v_q && pend_a_q == A_COUNT)) |=> (cnt_q == $past(cnt_q)));

  // R4
  cleared_means_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cleared_o |-> (cnt_q == '0));

  // R7
  lockout_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != '0 && req_i && we_i) |=> !pend_v_q);

  // R7
  sel_only_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> !$past(start_q));

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmp_a_match_o) |-> $past(pend_v_q && pend_a_q == A_STAT));
endmodule

bind cc_timer_core cc_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .LOCK_W(LOCK_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .cmp_a_match_o (cmp_a_match_o),
  .cleared_o     (cleared_o),
  .start_q       (start_q),
  .sel_q         (sel_q),
  .lock_q        (lock_q),
  .pend_v_q      (pend_v_q),
  .pend_a_q      (pend_a_q),
  .cnt_q         (cnt_q)
);

// File: tb/tb_cc_timer_core.sv
`timescale 1ns/1ps
module tb_cc_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src_en = '0;
  logic        fast = 1'b0;
  logic        cap = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        match_o, cleared;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cc_timer_core dut (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .fast_src_i(fast),
    .cap_a_i(cap), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cmp_a_match_o(match_o), .cleared_o(cleared)
  );

  // behavioural reference model
  logic [15:0] m_cnt, m_cmpa, m_pd, m_rdata;
  logic [2:0]  m_sel;
  logic [1:0]  m_pa;
  logic        m_start, m_clrm, m_fm, m_fo, m_clr, m_pv, m_rdv;
  int          m_lock;
  logic        fs1, fs2, fs3;

  function automatic logic src_on(input logic [2:0] s, input logic [5:0] en, input logic fr);
    if (s == 3'd0) return 1'b1;
    if (s == 3'd7) return fr;
    return en[s-1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmpa = 0; m_pd = 0; m_rdata = 0; m_sel = 0; m_pa = 0;
      m_start = 0; m_clrm = 0; m_fm = 0; m_fo = 0; m_clr = 0; m_pv = 0; m_rdv = 0;
      m_lock = 0; fs1 = 0; fs2 = 0; fs3 = 0;
    end else begin
      logic tick, hit, hclr, ov, acc;
      tick = m_start && src_on(m_sel, src_en, fs2 && !fs3);
      hit  = tick && (m_cnt == m_cmpa);
      hclr = m_start && m_clrm && (hit || cap);
      ov   = tick && !m_clrm && (m_cnt == 16'hFFFF);
      acc  = req && we && (m_lock == 0);
      m_rdv = req && !we;
      if (m_rdv) begin
        case (addr)
          2'd0: m_rdata = {11'd0, m_sel, m_clrm, m_start};
          2'd1: m_rdata = m_cnt;
          2'd2: m_rdata = m_cmpa;
          default: m_rdata = {14'd0, m_fo, m_fm};
        endcase
      end
      if (hclr) m_cnt = 0;
      else if (m_pv && m_pa == 2'd1) m_cnt = m_pd;
      else if (tick) m_cnt = m_cnt + 1;
      if (m_pv && m_pa == 2'd3) begin
        if (!m_pd[0]) m_fm = 0;
        if (!m_pd[1]) m_fo = 0;
      end
      if (hit) m_fm = 1;
      if (ov)  m_fo = 1;
      if (m_pv && m_pa == 2'd0 && !m_start && m_pd[4:2] != m_sel) begin
        m_sel = m_pd[4:2];
        m_lock = 2;
      end else if (m_lock > 0) m_lock = m_lock - 1;
      if (m_pv && m_pa == 2'd0) begin
        m_start = m_pd[0];
        m_clrm  = m_pd[1];
      end
      if (m_pv && m_pa == 2'd2) m_cmpa = m_pd;
      m_clr = hclr;
      m_pv = acc;
      if (acc) begin m_pa = addr; m_pd = wdata; end
      fs3 = fs2; fs2 = fs1; fs1 = fast;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(match_o === m_fm, "cmp_a_match_o", {15'd0, match_o}, {15'd0, m_fm});
      chk(cleared === m_clr, "cleared_o", {15'd0, cleared}, {15'd0, m_clr});
      if (m_rdv) chk(rdata === m_rdata, "rdata_o", rdata, m_rdata);
    end
  end

  // bus tasks: called at a negedge, return at the next negedge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      req = 0; we = 0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [15:0] exp, input string what);
    rd(a);
    chk(rdata === exp, what, rdata, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    rd_expect(0, 16'h0000, "reset ctrl");
    rd_expect(1, 16'h0000, "reset count");
    rd_expect(2, 16'h0000, "reset cmpa");
    rd_expect(3, 16'h0000, "reset status");

    // R2: code 0 counts every clock, stop holds
    cur_req = "R2";
    wr(0, 16'h0001);
    idle(10);
    wr(0, 16'h0000);
    idle(2);
    rd(1);
    idle(5);
    rd(1);
    // R10: write during counting replaces increment
    cur_req = "R10";
    wr(0, 16'h0001);
    wr(1, 16'h0100);
    idle(3);
    rd(1);
    wr(0, 16'h0000);
    idle(1);

    // R3: enable sources 1..6 and fast source
    cur_req = "R3";
    for (int k = 1; k < 8; k++) begin
      wr(0, 16'(k << 2));
      idle(3);
      wr(0, 16'((k << 2) | 1));
      for (int c = 0; c < 40; c++) begin
        src_en = 6'($urandom);
        if (k == 7 && (c % (1 + k % 3)) == 0) fast = ~fast;
        @(negedge clk);
      end
      wr(0, 16'(k << 2));
      idle(4);
      rd(1);
      rd(0);
    end
    src_en = '0;

    // R9: compare flag, sticky, cleared by writing 0
    cur_req = "R9";
    wr(0, 16'h0003 << 2);
    idle(3);
    wr(0, 16'h0000);
    idle(3);
    wr(1, 16'h0000);
    wr(2, 16'd6);
    wr(0, 16'h0001);
    idle(12);
    rd(3);
    wr(3, 16'h0002);
    idle(2);
    rd(3);

    // R8: wrap with overflow flag
    cur_req = "R8";
    wr(1, 16'hFFFC);
    idle(8);
    rd(3);
    wr(3, 16'h0003);
    idle(2);
    rd(3);
    wr(3, 16'h0001);
    idle(2);
    rd(3);
    wr(0, 16'h0000);
    idle(1);

    // R4: clear mode on compare, then capture
    cur_req = "R4";
    wr(1, 16'h0000);
    wr(2, 16'd5);
    wr(0, 16'h0003);
    idle(20);
    cap = 1;
    @(negedge clk);
    cap = 0;
    idle(3);
    rd(1);

    // R5: clear and write landing on the same edge
    cur_req = "R5";
    wr(2, 16'h0F00);
    idle(1);
    wr(1, 16'h1234);
    cap = 1;
    @(negedge clk);
    cap = 0;
    chk(cleared === 1'b1, "cleared after collision", {15'd0, cleared}, 16'h0001);
    rd(1);
    wr(0, 16'h0000);
    idle(2);

    // R6: posted write, immediate read is stale
    cur_req = "R6";
    wr(1, 16'h0055);
    idle(1);
    wr(1, 16'h00AA);
    rd_expect(1, 16'h0055, "read right after write");
    rd_expect(1, 16'h00AA, "read after gap");

    // R7: code change refused while running, lockout after change
    cur_req = "R7";
    wr(0, 16'h0001);
    wr(0, 16'h0009);
    idle(1);
    rd_expect(0, 16'h0001, "code kept while running");
    wr(0, 16'h0000);
    idle(1);
    wr(0, 16'h0008);
    wr(2, 16'h1111);
    wr(2, 16'h2222);
    wr(2, 16'h3333);
    idle(1);
    rd_expect(2, 16'h1111, "lockout drops writes");
    wr(2, 16'h4444);
    idle(1);
    rd_expect(2, 16'h4444, "write after lockout");
    rd_expect(0, 16'h0008, "new code taken when stopped");

    // random mix against the model
    cur_req = "R2";
    for (int c = 0; c < 4000; c++) begin
      src_en = 6'($urandom);
      if ($urandom_range(0, 2) == 0) fast = ~fast;
      cap = ($urandom_range(0, 30) == 0);
      req = ($urandom_range(0, 2) == 0);
      we = $urandom_range(0, 1) == 1;
      addr = 2'($urandom);
      wdata = (addr == 2'd1 && $urandom_range(0, 1) == 1) ? 16'hFFF0 : 16'($urandom_range(0, 40));
      @(negedge clk);
    end
    cap = 0;
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule